// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Interrupts

This block sits between a host register interface and a serial bus protocol engine. It holds two byte queues of equal depth. The transmit queue is filled by the host and drained by the engine. The receive queue is filled by the engine and drained by the host. Each queue has a programmable threshold. The block folds queue levels, threshold crossings and engine events into one 32-bit interrupt vector. Level bits follow the queue state. Event bits latch until the host clears them by writing ones. A mask selects which bits drive the single interrupt line.

All four byte interfaces use valid/ready. A byte moves on a clock edge where both valid and ready are high. A producer may hold valid while ready is low and must keep its data stable. The one exception is the host transmit side: when the host presents valid while the transmit queue is full, the byte is dropped and an overrun event is latched. Each queue can be flushed separately. A flush takes several cycles, and while either flush runs every byte interface stalls.

Top module: `fifo_pair_irq`

## Requirements
- R1: After reset both queues are empty, no flush is running, the mask is zero, `irq` is low, and the raw vector shows only the level bits the empty queues imply.
- R2: Host transmit bytes leave on the engine transmit side in the order they were accepted. `host_tx_ready` is high exactly when the queue holds fewer than DEPTH bytes and no flush runs. `eng_tx_valid` is high when the queue is non-empty and no flush runs.
- R3: Engine receive bytes reach `host_rx_data` in order, with back-pressure through `eng_rx_ready`. `host_rx_data` reads zero while the receive queue is empty, and a read attempt on an empty queue changes nothing.
- R4: Raw level bits are as follows. Bit 0 is TX empty. Bit 1 is TX count <= `tx_thresh`. Bit 2 is TX full. Bit 4 is RX empty. Bit 5 is RX count >= `rx_thresh`. Bit 6 is RX full. The thresholds are 4-bit values from 0 to 15.
- R5: Bit 3 (TX overrun) latches when `host_tx_valid` is high, the TX queue is full and no flush runs. The byte is dropped and the queue is unchanged.
- R6: Engine event pulses latch in the raw vector. Done with stop is bit 19, arbitration lost is bit 24, bus error is bit 25, and done without stop is bit 28.
- R7: A clear write removes latched bits where `clr_wdata` has a one, limited to the clearable set 0x131F007F. An event arriving in the same cycle as its clear wins.
- R8: Writes to the mask keep bits 31:29 at zero. `masked_status` is raw ANDed with mask, and `irq` is the OR of `masked_status`.
- R9: A flush request on an idle queue raises its busy flag on the next edge. The queue then drops one byte per cycle, and busy falls one edge after the queue reaches empty, so N bytes give N+1 busy cycles. A request made while that queue's flush already runs is ignored.
- R10: While either busy flag is high, `host_tx_ready`, `host_rx_valid`, `eng_tx_valid` and `eng_rx_ready` are all low, and no byte is pushed or popped except by the flush.
- R11: All raw bits other than 0-6, 19, 24, 25 and 28 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_tx_valid | input | 1 | Host offers a transmit byte |
| host_tx_ready | output | 1 | Transmit queue accepts a byte |
| host_tx_data | input | 8 | Transmit byte from host |
| host_rx_valid | output | 1 | Receive byte available to host |
| host_rx_ready | input | 1 | Host takes the receive byte |
| host_rx_data | output | 8 | Head of receive queue, zero when empty |
| eng_tx_valid | output | 1 | Transmit byte available to engine |
| eng_tx_ready | input | 1 | Engine takes the transmit byte |
| eng_tx_data | output | 8 | Head of transmit queue, zero when empty |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_ready | output | 1 | Receive queue accepts a byte |
| eng_rx_data | input | 8 | Received byte from engine |
| evt_done_stop | input | 1 | Pulse: transaction finished with stop |
| evt_arb_lost | input | 1 | Pulse: arbitration lost |
| evt_bus_err | input | 1 | Pulse: bus error |
| evt_done_nostop | input | 1 | Pulse: transaction finished without stop |
| tx_thresh | input | 4 | Transmit low-level threshold |
| rx_thresh | input | 4 | Receive high-level threshold |
| flush_tx_req | input | 1 | Start transmit flush |
| flush_rx_req | input | 1 | Start receive flush |
| flush_tx_busy | output | 1 | Transmit flush running |
| flush_rx_busy | output | 1 | Receive flush running |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 32 | Mask write value |
| mask_q | output | 32 | Current mask |
| clr_we | input | 1 | Clear write strobe |
| clr_wdata | input | 32 | Write-one-to-clear value |
| raw_status | output | 32 | Raw interrupt vector |
| masked_status | output | 32 | Raw vector ANDed with mask |
| irq | output | 1 | Interrupt line |

## Verification
A handshake, flush step, mask write or clear write on edge k shows on the ports right after edge k. The queue heads, ready/valid flags and level bits are combinational from registered counts, so they move in that same cycle. An event pulse sampled on edge k is latched and visible from edge k on. `masked_status` and `irq` follow raw and mask with no added delay. The bench drives inputs just after a rising edge and compares every output against its reference at the falling edge. It then advances the reference by one step with the inputs that the next rising edge will sample, so each result is checked in the first cycle it is due.

// File: rtl/fpi_pkg.sv
package fpi_pkg;
  localparam int VEC_W = 32;

  localparam int BIT_TX_EMPTY    = 0;
  localparam int BIT_TX_LOW      = 1;
  localparam int BIT_TX_FULL     = 2;
  localparam int BIT_TX_OVR      = 3;
  localparam int BIT_RX_EMPTY    = 4;
  localparam int BIT_RX_HIGH     = 5;
  localparam int BIT_RX_FULL     = 6;
  localparam int BIT_DONE_STOP   = 19;
  localparam int BIT_ARB_LOST    = 24;
  localparam int BIT_BUS_ERR     = 25;
  localparam int BIT_DONE_NOSTOP = 28;

  localparam logic [VEC_W-1:0] CLEARABLE  = 32'h131F_007F;
  localparam logic [VEC_W-1:0] MASK_AVAIL = 32'h1FFF_FFFF;
  localparam logic [VEC_W-1:0] STICKY_SET =
      (32'h1 << BIT_TX_OVR) | (32'h1 << BIT_DONE_STOP) | (32'h1 << BIT_ARB_LOST) |
      (32'h1 << BIT_BUS_ERR) | (32'h1 << BIT_DONE_NOSTOP);
endpackage

// File: rtl/fpi_byte_queue.sv
module fpi_byte_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  input  logic          flush_req_i,
  output logic          flush_busy_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;
  logic          busy_q;
  logic          drain, do_pop;
  logic [AW-1:0] wr_nxt, rd_nxt;

  assign empty_o      = (count_q == '0);
  assign full_o       = (count_q == CW'(DEPTH));
  assign count_o      = count_q;
  assign flush_busy_o = busy_q;
  assign head_o       = empty_o ? '0 : mem[rd_ptr];
  assign drain        = busy_q && !empty_o;
  assign do_pop       = pop_i || drain;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      if (push_i) wr_ptr <= wr_nxt;
      if (do_pop) rd_ptr <= rd_nxt;
      count_q <= count_q + CW'(push_i) - CW'(do_pop);
      if (busy_q) begin
        if (empty_o) busy_q <= 1'b0;
      end else if (flush_req_i) begin
        busy_q <= 1'b1;
      end
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !push_i);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> !pop_i);
  assert_flush_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !empty_o) |=> (count_q == $past(count_q) - 1'b1));
  assert_flush_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && empty_o) |=> !busy_q);
endmodule

// File: rtl/fpi_irq_regs.sv
module fpi_irq_regs
  import fpi_pkg::*;
#(
  parameter int CW = 5,
  parameter int TW = 4,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    tx_count_i,
  input  logic [CW-1:0]    rx_count_i,
  input  logic [TW-1:0]    tx_thr_i,
  input  logic [TW-1:0]    rx_thr_i,
  input  logic [VEC_W-1:0] evt_i,
  input  logic             mask_we_i,
  input  logic [VEC_W-1:0] mask_wdata_i,
  input  logic             clr_we_i,
  input  logic [VEC_W-1:0] clr_wdata_i,
  output logic [VEC_W-1:0] raw_o,
  output logic [VEC_W-1:0] mask_o,
  output logic [VEC_W-1:0] masked_o,
  output logic             irq_o
);
  logic [VEC_W-1:0] sticky_q, mask_q, level, clr_vec;

  always_comb begin
    level = '0;
    level[BIT_TX_EMPTY] = (tx_count_i == '0);
    level[BIT_TX_LOW]   = (tx_count_i <= CW'(tx_thr_i));
    level[BIT_TX_FULL]  = (tx_count_i == CW'(DEPTH));
    level[BIT_RX_EMPTY] = (rx_count_i == '0);
    level[BIT_RX_HIGH]  = (rx_count_i >= CW'(rx_thr_i));
    level[BIT_RX_FULL]  = (rx_count_i == CW'(DEPTH));
  end

  assign clr_vec = clr_we_i ? (clr_wdata_i & CLEARABLE) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      mask_q   <= '0;
    end else begin
      sticky_q <= (sticky_q & ~clr_vec) | (evt_i & STICKY_SET);
      if (mask_we_i) mask_q <= mask_wdata_i & MASK_AVAIL;
    end
  end

  assign raw_o    = level | sticky_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_o & mask_q;
  assign irq_o    = |masked_o;

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky_q & ~clr_vec) != '0) |=> (($past(sticky_q & ~clr_vec) & ~sticky_q) == '0));
  assert_event_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & STICKY_SET) != '0) |=> ((sticky_q & $past(evt_i & STICKY_SET)) == $past(evt_i & STICKY_SET)));
  assert_mask_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> (mask_o[31:29] == 3'b000));
endmodule

// File: rtl/fifo_pair_irq.sv
module fifo_pair_irq
  import fpi_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int TW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_tx_valid,
  output logic          host_tx_ready,
  input  logic [DW-1:0] host_tx_data,
  output logic          host_rx_valid,
  input  logic          host_rx_ready,
  output logic [DW-1:0] host_rx_data,
  output logic          eng_tx_valid,
  input  logic          eng_tx_ready,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_rx_valid,
  output logic          eng_rx_ready,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          evt_done_stop,
  input  logic          evt_arb_lost,
  input  logic          evt_bus_err,
  input  logic          evt_done_nostop,
  input  logic [TW-1:0] tx_thresh,
  input  logic [TW-1:0] rx_thresh,
  input  logic          flush_tx_req,
  input  logic          flush_rx_req,
  output logic          flush_tx_busy,
  output logic          flush_rx_busy,
  input  logic          mask_we,
  input  logic [31:0]   mask_wdata,
  output logic [31:0]   mask_q,
  input  logic          clr_we,
  input  logic [31:0]   clr_wdata,
  output logic [31:0]   raw_status,
  output logic [31:0]   masked_status,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic any_busy, tx_push, tx_pop, rx_push, rx_pop, overrun;
  logic [VEC_W-1:0] evt;

  assign any_busy      = flush_tx_busy || flush_rx_busy;
  assign host_tx_ready = !any_busy && !tx_full;
  assign eng_tx_valid  = !any_busy && !tx_empty;
  assign eng_rx_ready  = !any_busy && !rx_full;
  assign host_rx_valid = !any_busy && !rx_empty;
  assign tx_push       = host_tx_valid && host_tx_ready;
  assign tx_pop        = eng_tx_valid && eng_tx_ready;
  assign rx_push       = eng_rx_valid && eng_rx_ready;
  assign rx_pop        = host_rx_valid && host_rx_ready;
  assign overrun       = host_tx_valid && !any_busy && tx_full;

  always_comb begin
    evt = '0;
    evt[BIT_TX_OVR]      = overrun;
    evt[BIT_DONE_STOP]   = evt_done_stop;
    evt[BIT_ARB_LOST]    = evt_arb_lost;
    evt[BIT_BUS_ERR]     = evt_bus_err;
    evt[BIT_DONE_NOSTOP] = evt_done_nostop;
  end

  fpi_byte_queue #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push_i(tx_push), .push_data_i(host_tx_data),
    .pop_i(tx_pop), .head_o(eng_tx_data),
    .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty),
    .flush_req_i(flush_tx_req), .flush_busy_o(flush_tx_busy)
  );

  fpi_byte_queue #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_i(rx_push), .push_data_i(eng_rx_data),
    .pop_i(rx_pop), .head_o(host_rx_data),
    .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty),
    .flush_req_i(flush_rx_req), .flush_busy_o(flush_rx_busy)
  );

  fpi_irq_regs #(.CW(CW), .TW(TW), .DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .tx_count_i(tx_cnt), .rx_count_i(rx_cnt),
    .tx_thr_i(tx_thresh), .rx_thr_i(rx_thresh),
    .evt_i(evt),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
    .clr_we_i(clr_we), .clr_wdata_i(clr_wdata),
    .raw_o(raw_status), .mask_o(mask_q), .masked_o(masked_status), .irq_o(irq)
  );

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_busy |-> (!host_tx_ready && !host_rx_valid && !eng_tx_valid && !eng_rx_ready));
  assert_overrun_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !tx_pop) |=> (tx_cnt == $past(tx_cnt)));
endmodule

// File: tb/test_fifo_pair_irq.sv
module test_fifo_pair_irq;
  localparam int DEPTH = 16;
  localparam logic [31:0] CLR_SET = 32'h131F_007F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_tx_valid = 0, host_rx_ready = 0, eng_tx_ready = 0, eng_rx_valid = 0;
  logic [7:0] host_tx_data = 0, eng_rx_data = 0;
  logic evt_done_stop = 0, evt_arb_lost = 0, evt_bus_err = 0, evt_done_nostop = 0;
  logic [3:0] tx_thresh = 4'd4, rx_thresh = 4'd3;
  logic flush_tx_req = 0, flush_rx_req = 0, mask_we = 0, clr_we = 0;
  logic [31:0] mask_wdata = 0, clr_wdata = 0;
  logic host_tx_ready, host_rx_valid, eng_tx_valid, eng_rx_ready;
  logic [7:0] host_rx_data, eng_tx_data;
  logic flush_tx_busy, flush_rx_busy, irq;
  logic [31:0] mask_q, raw_status, masked_status;

  fifo_pair_irq i_fifo_pair_irq (.*);

  always #2 clk = ~clk;

  int nvec = 0, nfail = 0;
  bit running = 0, first_cmp = 1, done = 0;

  logic [7:0] mtx[$], mrx[$];
  bit mtb = 0, mrb = 0;
  logic [31:0] msticky = 0, mmask = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && !done) begin
      automatic bit any = mtb || mrb;
      automatic int ts = mtx.size(), rs = mrx.size();
      automatic bit e_htr = !any && ts < DEPTH;
      automatic bit e_etv = !any && ts > 0;
      automatic bit e_err = !any && rs < DEPTH;
      automatic bit e_hrv = !any && rs > 0;
      automatic logic [7:0] e_etd = ts > 0 ? mtx[0] : 8'h00;
      automatic logic [7:0] e_hrd = rs > 0 ? mrx[0] : 8'h00;
      automatic logic [31:0] lvl = 0, raw, clr, ev = 0;
      lvl[0] = (ts == 0); lvl[1] = (ts <= tx_thresh); lvl[2] = (ts == DEPTH);
      lvl[4] = (rs == 0); lvl[5] = (rs >= rx_thresh); lvl[6] = (rs == DEPTH);
      raw = lvl | msticky;
      if (first_cmp) begin
        first_cmp = 0;
        chk("R1 reset raw", raw_status, 32'h0000_0013);
        chk("R1 reset irq/busy/mask", {irq, flush_tx_busy, flush_rx_busy, mask_q[28:0]}, 32'h0);
      end
      chk("R2 R10 tx handshake", {host_tx_ready, eng_tx_valid}, {e_htr, e_etv});
      chk("R2 tx data", eng_tx_data, e_etd);
      chk("R3 R10 rx handshake", {eng_rx_ready, host_rx_valid}, {e_err, e_hrv});
      chk("R3 rx data", host_rx_data, e_hrd);
      chk("R4 level bits", raw_status & 32'h77, raw & 32'h77);
      chk("R5 overrun bit", raw_status[3], raw[3]);
      chk("R6 R7 event bits", raw_status & 32'h1308_0000, raw & 32'h1308_0000);
      chk("R11 unused bits", raw_status & ~32'h1308_007F, 32'h0);
      chk("R8 mask", mask_q, mmask);
      chk("R8 masked", masked_status, raw & mmask);
      chk("R8 irq", irq, |(raw & mmask));
      chk("R9 busy", {flush_tx_busy, flush_rx_busy}, {mtb, mrb});
      // advance reference with inputs the next rising edge samples
      ev[3]  = host_tx_valid && !any && ts == DEPTH;
      ev[19] = evt_done_stop; ev[24] = evt_arb_lost;
      ev[25] = evt_bus_err;   ev[28] = evt_done_nostop;
      clr = clr_we ? (clr_wdata & CLR_SET) : 32'h0;
      msticky = (msticky & ~clr) | ev;
      if (mask_we) mmask = mask_wdata & 32'h1FFF_FFFF;
      if (mtb) begin
        if (ts > 0) void'(mtx.pop_front()); else mtb = 0;
      end else begin
        if (e_etv && eng_tx_ready) void'(mtx.pop_front());
        if (host_tx_valid && e_htr) mtx.push_back(host_tx_data);
        if (flush_tx_req) mtb = 1;
      end
      if (mrb) begin
        if (rs > 0) void'(mrx.pop_front()); else mrb = 0;
      end else begin
        if (e_hrv && host_rx_ready) void'(mrx.pop_front());
        if (eng_rx_valid && e_err) mrx.push_back(eng_rx_data);
        if (flush_rx_req) mrb = 1;
      end
    end
  end

  task automatic go(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic quiet();
    host_tx_valid = 0; host_rx_ready = 0; eng_tx_ready = 0; eng_rx_valid = 0;
    flush_tx_req = 0; flush_rx_req = 0; mask_we = 0; clr_we = 0;
    evt_done_stop = 0; evt_arb_lost = 0; evt_bus_err = 0; evt_done_nostop = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    automatic logic [31:0] lf = 32'hACE1_2468;
    go(3);
    rst_n = 1; running = 1;
    go(1);
    // R5: fill TX past full with engine stalled
    for (int i = 0; i < 18; i++) begin host_tx_valid = 1; host_tx_data = 8'(8'h10 + i); go(1); end
    quiet();
    mask_we = 1; mask_wdata = 32'hFFFF_FFFF; go(1); quiet();
    // R2: engine drains in order
    eng_tx_ready = 1; go(20); quiet();
    // R3: fill RX to full, then host drains and reads empty
    for (int i = 0; i < 18; i++) begin eng_rx_valid = 1; eng_rx_data = 8'(8'hA0 + i); go(1); end
    quiet();
    host_rx_ready = 1; go(20); quiet();
    // R9 R10: flush both with contents while all handshakes asserted
    for (int i = 0; i < 6; i++) begin host_tx_valid = 1; host_tx_data = 8'(i); eng_rx_valid = 1; eng_rx_data = 8'(8'h50 + i); go(1); end
    quiet();
    flush_tx_req = 1; flush_rx_req = 1; go(1);
    host_tx_valid = 1; eng_rx_valid = 1; host_rx_ready = 1; eng_tx_ready = 1; go(9); quiet();
    go(2);
    // R9: flush on empty queue, repeated request
    flush_tx_req = 1; go(3); quiet(); go(2);
    // R6 R7: events, partial clear, clear racing an event
    evt_done_stop = 1; evt_arb_lost = 1; go(1); quiet();
    evt_bus_err = 1; evt_done_nostop = 1; go(1); quiet();
    clr_we = 1; clr_wdata = 32'h0100_0000; go(1); quiet();
    clr_we = 1; clr_wdata = 32'hFFFF_FFFF; evt_bus_err = 1; go(1); quiet();
    clr_we = 1; clr_wdata = 32'hFFFF_FFFF; go(1); quiet();
    mask_we = 1; mask_wdata = 32'h0000_0020; go(2); quiet();
    // mixed traffic with boundary thresholds
    tx_thresh = 4'd15; rx_thresh = 4'd0;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (i == 1500) begin tx_thresh = 4'd7; rx_thresh = 4'd15; end
      host_tx_valid = lf[0] | lf[9]; host_tx_data = lf[15:8];
      eng_tx_ready = lf[1] & lf[10];
      eng_rx_valid = lf[2] | lf[11]; eng_rx_data = lf[23:16];
      host_rx_ready = lf[3] & lf[12];
      flush_tx_req = (lf[7:4] == 4'hF) && lf[13];
      flush_rx_req = (lf[7:4] == 4'h0) && lf[14];
      evt_done_stop = lf[20] & lf[21] & lf[22];
      evt_arb_lost = lf[24] & lf[25] & lf[26];
      evt_bus_err = lf[27] & lf[28] & lf[29];
      evt_done_nostop = lf[30] & lf[31] & lf[5];
      clr_we = lf[17] & lf[18]; clr_wdata = {lf[15:0], lf[31:16]};
      mask_we = (lf[11:8] == 4'h5); mask_wdata = ~lf;
      go(1);
    end
    quiet(); go(4);
    finish_run();
  end
endmodule